// File: doc/BRIEF.md
# Gaussian Mixture Cost Pipeline

This block scores one acoustic model against one observation vector and returns a single cost word. A model is a set of diagonal Gaussian mixtures. For every coefficient of a mixture, the observation element at the same position is subtracted from the stored mean. The magnitude of the difference is scaled by a precomputed inverse-deviation factor and squared. The squared terms of one mixture are summed, and the mixture's weight constant is added to the sum. The model's cost is the smallest of its mixture sums. Costs are negative log likelihoods, so a lower value marks a more likely model. Taking the minimum replaces an exact log-domain sum.

Model data arrives as a stream with one coefficient per clock. Each beat carries a mean, a scale and a weight, together with a valid flag and a model-start flag. The observation vector is held steady on a wide input. The block counts coefficient and mixture positions itself. When the last mixture of a model has been folded into the minimum, it raises a one-cycle done strobe and holds the cost until the next model completes. An upstream reader feeds the stream, and a downstream writer collects one cost per model.

Top module: `gmm_cost_pipe`

## Requirements
- R1: For each accepted beat at coefficient position i of a mixture, the term is (|mean − obs[i]| × scale)², where mean and obs are signed 16-bit values in 8.8 format, scale is unsigned 8-bit in 2.6 format, and obs[i] occupies bits [16i+15:16i] of the observation input.
- R2: Each squared term is shifted right by 6 bits, from 28 to 22 fraction bits. The shifted terms of the NUM_COEF beats of one mixture are summed, and each mixture's sum starts afresh from its first coefficient.
- R3: The 32-bit unsigned weight presented with a mixture's last coefficient is added to that mixture's sum.
- R4: The model cost is the minimum of the mixture costs over all mixtures of the model. The minimum is loaded, not compared, for the first mixture.
- R5: The mixture count is sampled on the model-start beat. A count of 0 is treated as 1.
- R6: The coefficient sum and the weight addition both saturate at 0xFFFFFFFF instead of wrapping.
- R7: After reset the done output is low and the cost is 0xFFFFFFFF. Done is high for exactly one cycle, in the fourth clock after the edge that accepts the model's last coefficient. The cost output changes only together with done.
- R8: A beat with the model-start flag set begins a new model at coefficient 0 and mixture 0. Any unfinished model is dropped and produces no done.
- R9: Beats with valid low are ignored. Valid beats without the start flag that arrive while no model is open are ignored and leave done and the cost unchanged.
- R10: Models may follow each other with no idle cycle between them, and each one produces its own done and cost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Stream beat present |
| inModelStart | input | 1 | Beat is the first coefficient of a model |
| inMixCount | input | MIX_W | Number of mixtures in the model, sampled with the start beat |
| inMean | input | COEF_W | Mean coefficient, signed 8.8 |
| inScale | input | SCALE_W | Inverse-deviation factor, unsigned 2.6 |
| inAlpha | input | COST_W | Mixture weight, read on the mixture's last coefficient |
| obsVec | input | NUM_COEF*COEF_W | Observation vector, element i at bits [16i+15:16i] |
| costOut | output | COST_W | Lowest mixture cost of the last completed model |
| costDone | output | 1 | One-cycle strobe when costOut takes a new value |

## Verification
The bench builds the block with five coefficients per mixture and up to eight mixtures, while keeping the 16/8/32-bit data widths. With these values a full mixture takes only five beats, so the test can cover many models, the eight-mixture ceiling, back-to-back models and abandoned models within a short run. The unchanged data widths mean that a single extreme coefficient, or a weight near full scale, pushes both saturation points over the limit. A behavioural model in the bench predicts the done cycle and the cost on every clock.

// File: rtl/gmm_pkg.sv
package gmm_pkg;

  // Strobes that the sequencer hands to the datapath for one beat.
  typedef struct packed {
    logic take;       // beat enters the pipeline
    logic mixFirst;   // coefficient 0 of a mixture
    logic mixLast;    // final coefficient of a mixture
    logic firstMix;   // beat belongs to mixture 0 of the model
    logic modelLast;  // final coefficient of the final mixture
  } gmmCtrl_t;

endpackage

// File: rtl/gmm_ctrl.sv
module gmm_ctrl
  import gmm_pkg::*;
#(
  parameter int NUM_COEF = 39,
  parameter int MAX_MIX  = 16,
  parameter int IDX_W    = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1,
  parameter int MIX_W    = $clog2(MAX_MIX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inModelStart,
  input  logic [MIX_W-1:0] inMixCount,
  output gmmCtrl_t         ctrl,
  output logic [IDX_W-1:0] coefSel
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);
  localparam logic [MIX_W-1:0] ONE_MIX  = MIX_W'(1);

  logic             busy;
  logic [IDX_W-1:0] coefIdx;
  logic [MIX_W-1:0] mixIdx;
  logic [MIX_W-1:0] mixTotal;

  logic             startBeat;
  logic [IDX_W-1:0] curIdx;
  logic [MIX_W-1:0] curMix;
  logic [MIX_W-1:0] curTotal;

  always_comb begin
    startBeat = inValid && inModelStart;
    curIdx    = startBeat ? '0 : coefIdx;
    curMix    = startBeat ? '0 : mixIdx;
    if (startBeat) curTotal = (inMixCount == '0) ? ONE_MIX : inMixCount;
    else           curTotal = mixTotal;

    ctrl.take      = inValid && (inModelStart || busy);
    ctrl.mixFirst  = (curIdx == '0);
    ctrl.mixLast   = (curIdx == LAST_IDX);
    ctrl.firstMix  = (curMix == '0);
    ctrl.modelLast = ctrl.mixLast && (curMix == curTotal - ONE_MIX);
    coefSel        = curIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      coefIdx  <= '0;
      mixIdx   <= '0;
      mixTotal <= ONE_MIX;
    end else if (ctrl.take) begin
      mixTotal <= curTotal;
      if (ctrl.mixLast) begin
        coefIdx <= '0;
        if (ctrl.modelLast) begin
          mixIdx <= '0;
          busy   <= 1'b0;
        end else begin
          mixIdx <= curMix + ONE_MIX;
          busy   <= 1'b1;
        end
      end else begin
        coefIdx <= curIdx + IDX_W'(1);
        mixIdx  <= curMix;
        busy    <= 1'b1;
      end
    end
  end

  // R2: the position counter never leaves the mixture's coefficient range.
  a_r2_idx_range: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.take |-> (coefIdx <= LAST_IDX));

  // R5: an open model always has at least one mixture.
  a_r5_mix_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (mixTotal != '0));

endmodule

// File: rtl/gmm_datapath.sv
module gmm_datapath
  import gmm_pkg::*;
#(
  parameter int NUM_COEF = 39,
  parameter int COEF_W   = 16,
  parameter int SCALE_W  = 8,
  parameter int COST_W   = 32,
  parameter int SQ_SHIFT = 6,
  parameter int IDX_W    = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  gmmCtrl_t                   ctrl,
  input  logic [IDX_W-1:0]           coefSel,
  input  logic [COEF_W-1:0]          inMean,
  input  logic [SCALE_W-1:0]         inScale,
  input  logic [COST_W-1:0]          inAlpha,
  input  logic [NUM_COEF*COEF_W-1:0] obsVec,
  output logic [COST_W-1:0]          costOut,
  output logic                       costDone
);

  localparam int DIFF_W = COEF_W + 1;
  localparam int PROD_W = DIFF_W + SCALE_W;
  localparam int SQ_W   = 2 * PROD_W;
  localparam logic [COST_W-1:0] COST_MAX = {COST_W{1'b1}};

  function automatic logic [COST_W-1:0] satAdd(input logic [COST_W-1:0] a,
                                               input logic [COST_W-1:0] b);
    logic [COST_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[COST_W] ? COST_MAX : s[COST_W-1:0];
  endfunction

  // Observation elements unpacked from the flat input.
  logic [COEF_W-1:0] obsArr [NUM_COEF];
  for (genvar g = 0; g < NUM_COEF; g++) begin : g_obs
    assign obsArr[g] = obsVec[g*COEF_W +: COEF_W];
  end

  // Stage A inputs: difference magnitude and scaled product.
  logic [COEF_W-1:0]        obsSel;
  logic signed [DIFF_W-1:0] diffS;
  logic [DIFF_W-1:0]        absDiff;
  logic [PROD_W-1:0]        prodNext;

  always_comb begin
    obsSel   = obsArr[coefSel];
    diffS    = $signed({inMean[COEF_W-1], inMean}) - $signed({obsSel[COEF_W-1], obsSel});
    absDiff  = diffS[DIFF_W-1] ? DIFF_W'(-diffS) : DIFF_W'(diffS);
    prodNext = PROD_W'(absDiff) * PROD_W'(inScale);
  end

  // Stage A registers
  logic              aValid, aMixFirst, aMixLast, aFirstMix, aModelLast;
  logic [PROD_W-1:0] aProd;
  logic [COST_W-1:0] aAlpha;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aValid <= 1'b0;
      {aMixFirst, aMixLast, aFirstMix, aModelLast} <= '0;
      aProd  <= '0;
      aAlpha <= '0;
    end else begin
      aValid <= ctrl.take;
      if (ctrl.take) begin
        aMixFirst  <= ctrl.mixFirst;
        aMixLast   <= ctrl.mixLast;
        aFirstMix  <= ctrl.firstMix;
        aModelLast <= ctrl.modelLast;
        aProd      <= prodNext;
        aAlpha     <= inAlpha;
      end
    end
  end

  // Stage B: square, realign the fraction, clamp to the cost width.
  logic [SQ_W-1:0]   sqFull;
  logic [SQ_W-1:0]   sqAligned;
  logic [COST_W-1:0] termNext;

  always_comb begin
    sqFull    = SQ_W'(aProd) * SQ_W'(aProd);
    sqAligned = sqFull >> SQ_SHIFT;
    termNext  = (|sqAligned[SQ_W-1:COST_W]) ? COST_MAX : sqAligned[COST_W-1:0];
  end

  logic              bValid, bMixFirst, bMixLast, bFirstMix, bModelLast;
  logic [COST_W-1:0] bTerm;
  logic [COST_W-1:0] bAlpha;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bValid <= 1'b0;
      {bMixFirst, bMixLast, bFirstMix, bModelLast} <= '0;
      bTerm  <= '0;
      bAlpha <= '0;
    end else begin
      bValid <= aValid;
      if (aValid) begin
        bMixFirst  <= aMixFirst;
        bMixLast   <= aMixLast;
        bFirstMix  <= aFirstMix;
        bModelLast <= aModelLast;
        bTerm      <= termNext;
        bAlpha     <= aAlpha;
      end
    end
  end

  // Stage C: saturating accumulation over one mixture.
  logic              cValid, cMixLast, cFirstMix, cModelLast;
  logic [COST_W-1:0] accReg;
  logic [COST_W-1:0] cAlpha;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cValid <= 1'b0;
      {cMixLast, cFirstMix, cModelLast} <= '0;
      accReg <= '0;
      cAlpha <= '0;
    end else begin
      cValid <= bValid;
      if (bValid) begin
        accReg     <= bMixFirst ? bTerm : satAdd(accReg, bTerm);
        cMixLast   <= bMixLast;
        cFirstMix  <= bFirstMix;
        cModelLast <= bModelLast;
        cAlpha     <= bAlpha;
      end
    end
  end

  // R6: within a mixture the running sum never falls back (no wrap).
  a_r6_acc_monotonic: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bMixFirst) |=> (accReg >= $past(accReg)));

  // Stage D: weight added to the completed mixture sum.
  logic              dValid, dFirstMix, dModelLast;
  logic [COST_W-1:0] dCost;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dValid     <= 1'b0;
      dFirstMix  <= 1'b0;
      dModelLast <= 1'b0;
      dCost      <= '0;
    end else begin
      dValid <= cValid && cMixLast;
      if (cValid && cMixLast) begin
        dCost      <= satAdd(accReg, cAlpha);
        dFirstMix  <= cFirstMix;
        dModelLast <= cModelLast;
      end
    end
  end

  // Stage E: running minimum and result register.
  logic [COST_W-1:0] minReg;
  logic [COST_W-1:0] minNext;
  logic [COST_W-1:0] costReg;
  logic              doneReg;

  always_comb begin
    if (dFirstMix || (dCost < minReg)) minNext = dCost;
    else                               minNext = minReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      minReg  <= COST_MAX;
      costReg <= COST_MAX;
      doneReg <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      if (dValid) begin
        minReg <= minNext;
        if (dModelLast) begin
          costReg <= minNext;
          doneReg <= 1'b1;
        end
      end
    end
  end

  assign costOut  = costReg;
  assign costDone = doneReg;

  // R4: folding in a later mixture never raises the running minimum.
  a_r4_min_nonincreasing: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && !dFirstMix) |=> (minReg <= $past(minReg)));

  // R7: the reported cost only moves together with the done strobe.
  a_r7_cost_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(costReg) |-> doneReg);

  // R7: done follows a model-closing mixture exactly one stage later.
  a_r7_done_source: assert property (@(posedge clk) disable iff (!rstN)
    (dValid && dModelLast) |=> doneReg);

  // R7: done never rises without a closing mixture in the stage before it.
  a_r7_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneReg) |-> $past(dValid && dModelLast));

endmodule

// File: rtl/gmm_cost_pipe.sv
module gmm_cost_pipe
  import gmm_pkg::*;
#(
  parameter  int NUM_COEF = 39,
  parameter  int MAX_MIX  = 16,
  parameter  int COEF_W   = 16,
  parameter  int SCALE_W  = 8,
  parameter  int COST_W   = 32,
  parameter  int SQ_SHIFT = 6,
  localparam int MIX_W    = $clog2(MAX_MIX + 1),
  localparam int IDX_W    = (NUM_COEF > 1) ? $clog2(NUM_COEF) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  input  logic                       inModelStart,
  input  logic [MIX_W-1:0]           inMixCount,
  input  logic [COEF_W-1:0]          inMean,
  input  logic [SCALE_W-1:0]         inScale,
  input  logic [COST_W-1:0]          inAlpha,
  input  logic [NUM_COEF*COEF_W-1:0] obsVec,
  output logic [COST_W-1:0]          costOut,
  output logic                       costDone
);

  gmmCtrl_t         ctrl;
  logic [IDX_W-1:0] coefSel;

  gmm_ctrl #(
    .NUM_COEF(NUM_COEF),
    .MAX_MIX (MAX_MIX),
    .IDX_W   (IDX_W),
    .MIX_W   (MIX_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inModelStart(inModelStart),
    .inMixCount  (inMixCount),
    .ctrl        (ctrl),
    .coefSel     (coefSel)
  );

  gmm_datapath #(
    .NUM_COEF(NUM_COEF),
    .COEF_W  (COEF_W),
    .SCALE_W (SCALE_W),
    .COST_W  (COST_W),
    .SQ_SHIFT(SQ_SHIFT),
    .IDX_W   (IDX_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .coefSel (coefSel),
    .inMean  (inMean),
    .inScale (inScale),
    .inAlpha (inAlpha),
    .obsVec  (obsVec),
    .costOut (costOut),
    .costDone(costDone)
  );

endmodule

// File: tb/gmm_cost_pipe_tb.sv
module gmm_cost_pipe_tb_top;

  localparam int NC    = 5;
  localparam int MM    = 8;
  localparam int MIX_W = $clog2(MM + 1);
  localparam longint CMAX = 64'h0000_0000_FFFF_FFFF;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inModelStart = 1'b0;
  logic [MIX_W-1:0] inMixCount = '0;
  logic [15:0]      inMean = '0;
  logic [7:0]       inScale = '0;
  logic [31:0]      inAlpha = '0;
  logic [NC*16-1:0] obsVec = '0;
  logic [31:0]      costOut;
  logic             costDone;

  always #2 clk = ~clk;

  gmm_cost_pipe #(.NUM_COEF(NC), .MAX_MIX(MM)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inModelStart(inModelStart),
    .inMixCount(inMixCount), .inMean(inMean), .inScale(inScale),
    .inAlpha(inAlpha), .obsVec(obsVec), .costOut(costOut), .costDone(costDone)
  );

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  bit     checking = 1'b0;
  string  curReq = "R7";
  int     obsArr [NC];
  bit [31:0] seed = 32'h1234_5678;

  longint qCyc [$];
  longint qCost [$];
  string  qReq [$];
  longint held = CMAX;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return int'(seed >> 8);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the predicted done cycle and held cost.
  always @(negedge clk) begin
    if (checking) begin
      bit expDone;
      string r;
      expDone = (qCyc.size() > 0) && (qCyc[0] == cyc);
      r = expDone ? qReq[0] : curReq;
      check(costDone === expDone, r, "done", longint'(costDone), longint'(expDone));
      if (expDone) begin
        held = qCost.pop_front();
        void'(qCyc.pop_front());
        void'(qReq.pop_front());
      end
      check(longint'(costOut) === held, r, "cost", longint'(costOut), held);
    end
  end

  function automatic longint satAdd(input longint a, input longint b);
    longint s;
    s = a + b;
    return (s > CMAX) ? CMAX : s;
  endfunction

  function automatic longint termRef(input int m, input int o, input int s);
    longint d, p, q;
    d = longint'(m) - longint'(o);
    if (d < 0) d = -d;
    p = d * longint'(s);
    q = (p * p) >>> 6;
    return (q > CMAX) ? CMAX : q;
  endfunction

  task automatic setObs(input int mode);
    for (int i = 0; i < NC; i++) begin
      if (mode == 1) obsArr[i] = -32768;
      else obsArr[i] = (nextRand() % 4096) - 2048;
      obsVec[i*16 +: 16] = 16'(obsArr[i]);
    end
  endtask

  task automatic idleBeat(input bit v);
    @(negedge clk);
    inValid      = v;
    inModelStart = 1'b0;
    inMean       = 16'(nextRand());
    inScale      = 8'(nextRand());
    inAlpha      = 32'(nextRand());
  endtask

  // mode 0: moderate data, 1: saturating terms, 2: weight near full scale,
  // 3: every mixture identical (ties)
  task automatic sendModel(input int nMix, input int countField, input int gap,
                           input int mode, input int keepBeats, input string req);
    longint best = CMAX;
    int beat = 0;
    int tieMean [NC];
    int tieScale [NC];
    for (int i = 0; i < NC; i++) begin
      tieMean[i]  = (nextRand() % 2048) - 1024;
      tieScale[i] = nextRand() % 256;
    end
    for (int mx = 0; mx < nMix; mx++) begin
      longint acc = 0;
      longint alpha;
      alpha = (mode == 2) ? (CMAX - longint'(nextRand() % 64)) : longint'(nextRand() % 65536);
      if (mode == 3) alpha = 1000;
      for (int i = 0; i < NC; i++) begin
        int m, s;
        if (keepBeats >= 0 && beat >= keepBeats) return;
        if (mode == 1)      begin m = 32767; s = 255; end
        else if (mode == 3) begin m = tieMean[i]; s = tieScale[i]; end
        else begin m = (nextRand() % 4096) - 2048; s = nextRand() % 256; end
        if (gap > 0 && beat > 0 && (beat % gap) == 0) idleBeat(1'b0);
        @(negedge clk);
        inValid      = 1'b1;
        inModelStart = (beat == 0);
        inMixCount   = MIX_W'(countField);
        inMean       = 16'(m);
        inScale      = 8'(s);
        inAlpha      = 32'(alpha);
        acc = (i == 0) ? termRef(m, obsArr[i], s) : satAdd(acc, termRef(m, obsArr[i], s));
        if (i == NC - 1) begin
          longint mc;
          mc = satAdd(acc, alpha);
          if (mx == 0 || mc < best) best = mc;
          if (mx == nMix - 1) begin
            qCyc.push_back(cyc + 1 + 4);
            qCost.push_back(best);
            qReq.push_back(req);
          end
        end
        beat++;
      end
    end
  endtask

  task automatic settle();
    @(negedge clk);
    inValid = 1'b0;
    inModelStart = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(costDone === 1'b0, "R7", "reset done", longint'(costDone), 0);
    check(longint'(costOut) === CMAX, "R7", "reset cost", longint'(costOut), CMAX);
    rstN = 1'b1;
    checking = 1'b1;

    curReq = "R1"; setObs(0); sendModel(1, 1, 0, 0, -1, "R1"); settle();
    curReq = "R2"; setObs(0); sendModel(2, 2, 0, 0, -1, "R2"); settle();
    curReq = "R3"; setObs(0); sendModel(1, 1, 0, 0, -1, "R3"); settle();
    curReq = "R4"; setObs(0); sendModel(3, 3, 0, 0, -1, "R4"); settle();
    curReq = "R4"; setObs(0); sendModel(MM, MM, 0, 0, -1, "R4"); settle();
    curReq = "R4"; setObs(0); sendModel(4, 4, 0, 3, -1, "R4"); settle();
    curReq = "R5"; setObs(0); sendModel(1, 0, 0, 0, -1, "R5"); settle();
    curReq = "R6"; setObs(1); sendModel(2, 2, 0, 1, -1, "R6"); settle();
    curReq = "R6"; setObs(0); sendModel(2, 2, 0, 2, -1, "R6"); settle();
    // R9: valid beats with no model open, then beats with gaps
    curReq = "R9";
    for (int k = 0; k < 12; k++) idleBeat(1'b1);
    settle();
    setObs(0); sendModel(3, 3, 2, 0, -1, "R9"); settle();
    // R8: abandoned model followed by a fresh one
    curReq = "R8"; setObs(0);
    sendModel(3, 3, 0, 0, 2 * NC + 2, "R8");
    sendModel(2, 2, 0, 0, -1, "R8"); settle();
    // R10: models back to back
    curReq = "R10"; setObs(0);
    for (int k = 0; k < 6; k++) sendModel(1 + (k % 3), 1 + (k % 3), 0, 0, -1, "R10");
    settle();
    check(qCyc.size() == 0, "R10", "pending dones", longint'(qCyc.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=%0h expected=%0h", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule